// File: doc/BRIEF.md
# Port Over-Current Recovery Controller

This block guards one downstream port. An external power switch signals a fault on a single flag line. The block resamples that flag and measures how long it stays asserted. Three outcomes follow from that length. A brief pulse soon after power-on is taken as inrush. A flag that stays up while the port is unpowered is taken as a hard short. Anything else is taken as an overload.

Each class has its own policy. An inrush spike is recorded and the port stays powered. A hard short locks the port off at once. An overload removes power for a cooldown window, then powers the port again. The cooldown doubles with each consecutive retry. When the retry budget is spent, the port is locked off. A port that stays fault-free for long enough gets its full retry budget back. Only a software clear pulse releases the lock.

Top module: `ocr_port_guard`

## Requirements
- R1: While reset is asserted, and on leaving it, the power enable, the lock indication and the fault code are all 0.
- R2: With `flag_act_high_i` = 1 a high flag level means fault. With it at 0 a low flag level means fault. Classification and cut-off behave the same in both cases.
- R3: A fault lasting fewer than `deb_i` cycles at the pin is ignored. The port stays powered and the fault code stays 0. A fault of `deb_i` or more cycles is qualified.
- R4: For INS_WIN cycles after the port powers up, a qualified pulse shorter than SPIKE_LEN cycles leaves the port powered and sets fault code 1 (inrush spike). A pulse of SPIKE_LEN cycles or more in that window cuts power.
- R5: If the fault stays asserted for SHORT_LEN cycles, the port locks off, `lockout_o` = 1 and the fault code is 2 (hard short).
- R6: Outside the insertion window, power drops no later than `deb_i`+4 cycles after the fault appears at the pin. It stays on for at least `deb_i` cycles.
- R7: A fault released before SHORT_LEN sets fault code 3 (overload). Power stays off for a cooldown, then returns by itself while `port_req_i` is high.
- R8: The k-th consecutive overload cooldown lasts BASE_COOL·2^(k-1) cycles. Power returns within 8 cycles after that length, counted from the flag release at the pin.
- R9: An overload that arrives after MAX_RETRY retries have been used locks the port off with fault code 3.
- R10: After STABLE_LEN fault-free powered cycles, the retry count resets to zero and the next cooldown is BASE_COOL again.
- R11: Only a `sw_clear_i` pulse leaves lockout. Toggling `port_req_i` does not. The clear also sets the fault code to 0 and resets the retry count.
- R12: Power is on only while `port_req_i` is high. It follows a change of the request within one cycle when no fault is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_i | input | 1 | Asynchronous fault flag from the power switch |
| flag_act_high_i | input | 1 | Polarity select: 1 means a high level is a fault |
| deb_i | input | DEB_W | Debounce length in cycles |
| port_req_i | input | 1 | Software request to power the port |
| sw_clear_i | input | 1 | Clear pulse: releases lockout, fault code and retry count |
| pwr_en_o | output | 1 | Port power switch enable |
| fault_type_o | output | 2 | 0 none, 1 inrush spike, 2 hard short, 3 overload |
| lockout_o | output | 1 | Port is latched off |

## Verification
A wrong internal state shows up at the ports in two ways. Either the enable pin toggles at the wrong cycle, or a fault code appears that does not match the pulse length.

- A stuck retry or backoff count changes the length of the next cooldown. This shows on the enable pin within one cooldown period.
- A debounce or window counter that is off by one changes the outcome of pulses exactly at the thresholds. This shows on the enable pin and the fault code within a few cycles of the flag release.
- A lock that can be left by any event other than a clear shows as the enable rising while `lockout_o` was expected to stay set.

// File: rtl/ocr_pkg.sv
package ocr_pkg;

  typedef enum logic [1:0] {
    FT_NONE     = 2'd0,
    FT_SPIKE    = 2'd1,
    FT_SHORT    = 2'd2,
    FT_OVERLOAD = 2'd3
  } fault_t;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_ON,
    ST_HOLD,
    ST_COOL,
    ST_LOCK
  } port_st_t;

  // cooldown length after a given number of retries already spent
  function automatic int unsigned backoff_cycles(input int unsigned base,
                                                 input int unsigned tries);
    return base << tries;
  endfunction

endpackage

// File: rtl/ocr_flag_filter.sv
module ocr_flag_filter #(
  parameter int RUN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_i,
  input  logic             act_high_i,
  output logic             fault_lvl_o,
  output logic [RUN_W-1:0] run_len_o
);

  logic meta_q, sync_q;
  logic [RUN_W-1:0] run_q;

  // polarity folded in before the first flop so the reset value is "no fault"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= flag_i ~^ act_high_i;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (!sync_q)          run_q <= '0;
    else if (run_q != '1)      run_q <= run_q + RUN_W'(1);
  end

  assign fault_lvl_o = sync_q;
  assign run_len_o   = run_q;

  // R3
  run_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && run_q != '1) |=> (run_q == $past(run_q) + RUN_W'(1)));

endmodule

// File: rtl/ocr_retry_budget.sv
module ocr_retry_budget
  import ocr_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  parameter int BASE_COOL = 256,
  parameter int CNT_W     = 2,
  parameter int COOL_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_i,
  input  logic              clear_i,
  output logic              exhausted_o,
  output logic [COOL_W-1:0] cool_len_o
);

  logic [CNT_W-1:0] retry_q;

  assign exhausted_o = retry_q >= CNT_W'(MAX_RETRY);
  assign cool_len_o  = COOL_W'(backoff_cycles(BASE_COOL, 32'(retry_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       retry_q <= '0;
    else if (clear_i)                 retry_q <= '0;
    else if (use_i && !exhausted_o)   retry_q <= retry_q + CNT_W'(1);
  end

  // R9
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q <= CNT_W'(MAX_RETRY));

  // R8
  backoff_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_i && !exhausted_o && !clear_i) |=>
      (cool_len_o == {$past(cool_len_o[COOL_W-2:0]), 1'b0}));

  // R10
  budget_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cool_len_o == COOL_W'(BASE_COOL)));

endmodule

// File: rtl/ocr_port_guard.sv
module ocr_port_guard
  import ocr_pkg::*;
#(
  parameter int DEB_W      = 8,
  parameter int SPIKE_LEN  = 64,
  parameter int SHORT_LEN  = 1024,
  parameter int INS_WIN    = 2048,
  parameter int BASE_COOL  = 256,
  parameter int MAX_RETRY  = 3,
  parameter int STABLE_LEN = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_i,
  input  logic             flag_act_high_i,
  input  logic [DEB_W-1:0] deb_i,
  input  logic             port_req_i,
  input  logic             sw_clear_i,
  output logic             pwr_en_o,
  output logic [1:0]       fault_type_o,
  output logic             lockout_o
);

  localparam int LEN_W  = $clog2(SHORT_LEN + 1);
  localparam int RUN_W  = ((LEN_W > DEB_W) ? LEN_W : DEB_W) + 1;
  localparam int WIN_W  = $clog2(INS_WIN + 1);
  localparam int OK_W   = $clog2(STABLE_LEN + 1);
  localparam int CNT_W  = $clog2(MAX_RETRY + 1);
  localparam int COOL_W = $clog2(BASE_COOL + 1) + MAX_RETRY;

  port_st_t          state_q, state_d;
  fault_t            fault_q;
  logic [WIN_W-1:0]  ins_cnt_q;
  logic [OK_W-1:0]   ok_cnt_q;
  logic [COOL_W-1:0] cool_cnt_q;

  logic              fault_lvl;
  logic [RUN_W-1:0]  run_len;
  logic              exhausted;
  logic [COOL_W-1:0] cool_len;

  // named internal events
  logic             in_win, cut_evt, spike_evt, short_evt, ovl_evt, stable_hit;
  logic [RUN_W-1:0] deb_ext, cut_thr;

  ocr_flag_filter #(.RUN_W(RUN_W)) u_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_i      (flag_i),
    .act_high_i  (flag_act_high_i),
    .fault_lvl_o (fault_lvl),
    .run_len_o   (run_len)
  );

  ocr_retry_budget #(
    .MAX_RETRY (MAX_RETRY),
    .BASE_COOL (BASE_COOL),
    .CNT_W     (CNT_W),
    .COOL_W    (COOL_W)
  ) u_budget (
    .clk         (clk),
    .rst_n       (rst_n),
    .use_i       (ovl_evt),
    .clear_i     (sw_clear_i || stable_hit),
    .exhausted_o (exhausted),
    .cool_len_o  (cool_len)
  );

  assign in_win     = ins_cnt_q < WIN_W'(INS_WIN);
  assign deb_ext    = RUN_W'(deb_i);
  assign cut_thr    = in_win ? RUN_W'(SPIKE_LEN) : deb_ext;
  assign cut_evt    = (state_q == ST_ON) && (run_len != '0) && (run_len >= cut_thr);
  assign spike_evt  = (state_q == ST_ON) && in_win && !fault_lvl && (run_len != '0)
                      && (run_len >= deb_ext) && (run_len < RUN_W'(SPIKE_LEN));
  assign short_evt  = (state_q == ST_HOLD) && (run_len >= RUN_W'(SHORT_LEN));
  assign ovl_evt    = (state_q == ST_HOLD) && !short_evt && !fault_lvl;
  assign stable_hit = ok_cnt_q == OK_W'(STABLE_LEN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  if (port_req_i) state_d = ST_ON;
      ST_ON: begin
        if (cut_evt)          state_d = ST_HOLD;
        else if (!port_req_i) state_d = ST_OFF;
      end
      ST_HOLD: begin
        if (short_evt)        state_d = ST_LOCK;
        else if (ovl_evt)     state_d = exhausted ? ST_LOCK : ST_COOL;
      end
      ST_COOL: if (cool_cnt_q == '0) state_d = port_req_i ? ST_ON : ST_OFF;
      ST_LOCK: if (sw_clear_i) state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_OFF;
      fault_q    <= FT_NONE;
      ins_cnt_q  <= '0;
      ok_cnt_q   <= '0;
      cool_cnt_q <= '0;
    end else begin
      state_q <= state_d;

      if (sw_clear_i)     fault_q <= FT_NONE;
      else if (spike_evt) fault_q <= FT_SPIKE;
      else if (short_evt) fault_q <= FT_SHORT;
      else if (ovl_evt)   fault_q <= FT_OVERLOAD;

      if (state_q != ST_ON) ins_cnt_q <= '0;
      else if (in_win)      ins_cnt_q <= ins_cnt_q + WIN_W'(1);

      if (state_q != ST_ON || fault_lvl) ok_cnt_q <= '0;
      else if (!stable_hit)              ok_cnt_q <= ok_cnt_q + OK_W'(1);

      if (ovl_evt && !exhausted)                    cool_cnt_q <= cool_len - COOL_W'(1);
      else if (state_q == ST_COOL && cool_cnt_q != '0) cool_cnt_q <= cool_cnt_q - COOL_W'(1);
    end
  end

  assign pwr_en_o     = state_q == ST_ON;
  assign lockout_o    = state_q == ST_LOCK;
  assign fault_type_o = fault_q;

  // R6
  cut_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en_o && !in_win && deb_i != '0 && run_len >= deb_ext) |=> !pwr_en_o);

  // R4
  spike_keeps_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spike_evt && port_req_i) |=> pwr_en_o);

  // R5
  short_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_evt && !sw_clear_i) |=> (lockout_o && fault_type_o == FT_SHORT));

  // R11
  lock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockout_o) |-> $past(sw_clear_i));

  // R12
  power_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_o) |-> $past(port_req_i));

endmodule

// File: tb/tb_ocr_port_guard.sv
module tb_ocr_port_guard;

  localparam int DEB   = 3;
  localparam int SPIKE = 10;
  localparam int SHORT = 40;
  localparam int WIN   = 24;
  localparam int BASE  = 20;
  localparam int MAXR  = 2;
  localparam int STAB  = 100;

  logic       clk = 1'b0;
  logic       rst_n, flag, act_high, port_req, sw_clear;
  logic [7:0] deb;
  logic       pwr_en, lockout;
  logic [1:0] ftype;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  ocr_port_guard #(
    .DEB_W(8), .SPIKE_LEN(SPIKE), .SHORT_LEN(SHORT), .INS_WIN(WIN),
    .BASE_COOL(BASE), .MAX_RETRY(MAXR), .STABLE_LEN(STAB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .flag_i(flag), .flag_act_high_i(act_high),
    .deb_i(deb), .port_req_i(port_req), .sw_clear_i(sw_clear),
    .pwr_en_o(pwr_en), .fault_type_o(ftype), .lockout_o(lockout)
  );

  typedef struct packed {
    logic       hi;
    logic       early;
    logic [7:0] len;
    logic       exp_pwr;
    logic [1:0] exp_type;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd2,  1'b1, 2'd0},
    '{1'b0, 1'b0, 8'd3,  1'b0, 2'd3},
    '{1'b0, 1'b1, 8'd6,  1'b1, 2'd1},
    '{1'b0, 1'b1, 8'd12, 1'b0, 2'd3},
    '{1'b1, 1'b0, 8'd2,  1'b1, 2'd0},
    '{1'b1, 1'b0, 8'd15, 1'b0, 2'd3},
    '{1'b1, 1'b1, 8'd9,  1'b1, 2'd1},
    '{1'b0, 1'b0, 8'd1,  1'b1, 2'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_fault(input logic on);
    flag = on ? act_high : ~act_high;
  endtask

  task automatic pulse(input int len);
    drive_fault(1'b1);
    cyc(len);
    drive_fault(1'b0);
  endtask

  // power down, let any cooldown drain, clear, then power up (port ON after return)
  task automatic restart();
    port_req = 1'b0;
    cyc(90);
    sw_clear = 1'b1;
    cyc(1);
    sw_clear = 1'b0;
    port_req = 1'b1;
    cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; act_high = 1'b0; flag = 1'b1; port_req = 1'b0;
    sw_clear = 1'b0; deb = 8'(DEB);
    cyc(4);
    // R1 during reset
    check("R1 pwr in reset", int'(pwr_en), 0);
    check("R1 lock in reset", int'(lockout), 0);
    check("R1 type in reset", int'(ftype), 0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 pwr after reset", int'(pwr_en), 0);

    // R12 request follows
    port_req = 1'b1; cyc(1);
    check("R12 pwr on request", int'(pwr_en), 1);
    port_req = 1'b0; cyc(1);
    check("R12 pwr off request", int'(pwr_en), 0);

    // table: polarity, debounce and insertion-window classification
    for (int i = 0; i < NV; i++) begin
      string tag;
      act_high = VECS[i].hi;
      flag = ~VECS[i].hi;
      restart();
      if (!VECS[i].early) cyc(30);
      pulse(int'(VECS[i].len));
      cyc(6);
      tag = VECS[i].hi ? "R2" : (VECS[i].early ? "R4" : "R3");
      check($sformatf("%s vec%0d pwr", tag, i), int'(pwr_en), int'(VECS[i].exp_pwr));
      check($sformatf("%s vec%0d type", tag, i), int'(ftype), int'(VECS[i].exp_type));
    end

    act_high = 1'b0; flag = 1'b1;

    // R6 cut latency, then R5 persistent short
    restart(); cyc(30);
    drive_fault(1'b1);
    cyc(DEB);
    check("R6 still on at deb", int'(pwr_en), 1);
    cyc(4);
    check("R6 off by deb+4", int'(pwr_en), 0);
    cyc(60);
    check("R5 lockout", int'(lockout), 1);
    check("R5 type short", int'(ftype), 2);
    check("R5 pwr off", int'(pwr_en), 0);
    drive_fault(1'b0);
    // R11 request toggling does not release
    port_req = 1'b0; cyc(5); port_req = 1'b1; cyc(5);
    check("R11 lock held", int'(lockout), 1);
    check("R11 pwr held off", int'(pwr_en), 0);
    sw_clear = 1'b1; cyc(1); sw_clear = 1'b0; cyc(3);
    check("R11 lock released", int'(lockout), 0);
    check("R11 type cleared", int'(ftype), 0);
    check("R11 pwr back", int'(pwr_en), 1);

    // R7 / R8 / R9 doubling cooldown then lockout
    restart(); cyc(30);
    pulse(15); cyc(BASE);
    check("R8 first cooldown off", int'(pwr_en), 0);
    cyc(8);
    check("R7 auto re-enable", int'(pwr_en), 1);
    cyc(30);
    pulse(15); cyc(2 * BASE);
    check("R8 second cooldown off", int'(pwr_en), 0);
    cyc(8);
    check("R8 second re-enable", int'(pwr_en), 1);
    cyc(30);
    pulse(15); cyc(8);
    check("R9 lockout", int'(lockout), 1);
    check("R9 type overload", int'(ftype), 3);

    // R10 stable period refills budget
    restart(); cyc(30);
    pulse(15); cyc(BASE + 8);
    check("R10 first re-enable", int'(pwr_en), 1);
    cyc(STAB + 30);
    pulse(15); cyc(BASE);
    check("R10 cooldown off", int'(pwr_en), 0);
    cyc(8);
    check("R10 base cooldown again", int'(pwr_en), 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule